// File: doc/BRIEF.md
# Periodic Wake-up Interval Timer

This block produces recurring interrupt requests at intervals counted in ticks of a slow 32.768 kHz reference, so that a host processor can sleep between events and be woken at a precise rate. The reference arrives as a one-cycle enable (`tick_32k`) in the system clock domain. A free-running counter advances on each tick and is compared against a programmed interval. When the two meet, an interrupt is raised and the counter starts over.

The host reaches the block through a small byte-wide register window. The interval is written one byte at a time, and it only takes effect when its lowest byte is written. That write also restarts the count from zero. The running count is read one byte at a time as well. Reading its lowest byte freezes the upper bytes into holding registers, so a multi-byte read stays coherent. A control register holds an interrupt enable, a write-one clear strobe and a read-only pending flag. While the pending flag stays set, every register access re-issues the interrupt request, so a host that misses the first one is prompted again.

Top module: `wake_timer_top`

## Requirements
- R1: After reset the committed interval, the count, the holding registers, the enable and the pending flag are all zero, `irq_req` is low, and every register address reads 0x00.
- R2: Writing interval bytes 1 to 3 (addresses 1 to 3) only stages them. Reads of addresses 0 to 3 return the committed interval, byte n at address n, and the running interval does not change.
- R3: A write to address 0 commits that byte together with the staged bytes 1 to 3 as the new interval, and resets the count to zero in the same cycle.
- R4: While the committed interval is zero, the count holds its value and no match occurs.
- R5: The count advances by one only in cycles where `tick_32k` is high. When the incremented value would equal the interval, a match occurs and the count returns to zero, so a match comes once every interval ticks.
- R6: A read of address 4 returns the live low count byte and, in the same cycle, latches the whole count. Reads of addresses 5 to 7 return bytes 1 to 3 of the latched copy.
- R7: A match sets the pending flag and, when the interrupt is enabled, drives `irq_req` high for exactly the one cycle that follows the match.
- R8: Any register read or write made while the pending flag is set, other than a write that clears it, drives `irq_req` high for the following cycle when the interrupt is enabled.
- R9: The control register sits at address 8, with enable in bit 0, clear in bit 1 and pending in bit 2. Writing 1 to bit 1 clears the pending flag, and bit 1 always reads 0.
- R10: With enable at 0, `irq_req` stays low, but matches still set the pending flag.
- R11: When a match and a clear fall in the same cycle, the pending flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle enable at the 32.768 kHz rate |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of `reg_rd` |
| irq_req | output | 1 | One-cycle interrupt request pulse |

## Verification
A match, which sets the pending flag, and a control write that clears that flag can land in the same cycle. So can a match and an interval commit, which restarts the count. The bench provokes the first case directly: it commits a short interval, lets the count reach one tick before the match, then issues the clear write on the matching tick. It then reads the control register and expects pending still at 1. Random stimulus with short intervals and a 50% tick rate makes both collisions happen many more times. A cycle-by-cycle reference model in the bench decides each expected outcome.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int CNT_W    = 32;
  localparam int ADDR_W   = 4;
  localparam int BYTES    = CNT_W / 8;
  localparam int SEL_W    = $clog2(BYTES);
  localparam int ADR_CNT0 = BYTES;
  localparam int ADR_CTRL = 2 * BYTES;
  localparam int BIT_EN   = 0;
  localparam int BIT_CLR  = 1;
  localparam int BIT_PEND = 2;
endpackage

// File: rtl/wt_regs.sv
module wt_regs
  import wt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              pending,
  output logic [CNT_W-1:0]  period_q,
  output logic              commit,
  output logic              en_q,
  output logic              clear,
  output logic [7:0]        rdata
);
  logic             is_per, is_cnt, is_ctrl;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:8] stage_q, stage_d;
  logic [CNT_W-1:8] hold_q, hold_d;
  logic [CNT_W-1:0] period_d, commit_val, cnt_view;
  logic             en_d, snap_take;

  assign is_per    = (addr < ADDR_W'(BYTES));
  assign is_cnt    = (addr >= ADDR_W'(ADR_CNT0)) && (addr < ADDR_W'(ADR_CTRL));
  assign is_ctrl   = (addr == ADDR_W'(ADR_CTRL));
  assign sel       = addr[SEL_W-1:0];
  assign commit    = wr && is_per && (sel == '0);
  assign snap_take = rd && is_cnt && (sel == '0);
  assign clear     = wr && is_ctrl && wdata[BIT_CLR];

  assign commit_val[7:0] = wdata;
  genvar gi;
  generate
    for (gi = 1; gi < BYTES; gi++) begin : g_stage
      assign stage_d[8*gi +: 8]    = (wr && is_per && (sel == SEL_W'(gi))) ? wdata
                                                                           : stage_q[8*gi +: 8];
      assign commit_val[8*gi +: 8] = stage_q[8*gi +: 8];
    end
  endgenerate

  always_comb begin
    period_d = commit ? commit_val : period_q;
    hold_d   = snap_take ? count[CNT_W-1:8] : hold_q;
    en_d     = (wr && is_ctrl) ? wdata[BIT_EN] : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      hold_q   <= '0;
      period_q <= '0;
      en_q     <= 1'b0;
    end else begin
      stage_q  <= stage_d;
      hold_q   <= hold_d;
      period_q <= period_d;
      en_q     <= en_d;
    end
  end

  assign cnt_view = {hold_q, count[7:0]};

  always_comb begin
    rdata = 8'h00;
    if (is_per)
      rdata = period_q[{sel, 3'b000} +: 8];
    else if (is_cnt)
      rdata = cnt_view[{sel, 3'b000} +: 8];
    else if (is_ctrl) begin
      rdata[BIT_EN]   = en_q;
      rdata[BIT_PEND] = pending;
    end
  end

  p_stage_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && is_per && (sel != '0)) |=> $stable(period_q));
  p_snap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && is_cnt && (sel == '0)) |=> $stable(hold_q));
endmodule

// File: rtl/wt_count.sv
module wt_count
  import wt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             commit,
  input  logic [CNT_W-1:0] period_q,
  output logic [CNT_W-1:0] count_q,
  output logic             match
);
  logic [CNT_W-1:0] count_d, count_inc;
  logic             running;

  assign running   = (period_q != '0);
  assign count_inc = count_q + CNT_W'(1);
  assign match     = tick && !commit && running && (count_inc == period_q);

  always_comb begin
    count_d = count_q;
    if (commit)
      count_d = '0;
    else if (tick && running)
      count_d = match ? '0 : count_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  p_commit_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (count_q == '0));
  p_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !commit) |=> $stable(count_q));
  p_below_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (count_q < period_q));
  p_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !commit) |=> $stable(count_q));
endmodule

// File: rtl/wt_irq.sv
module wt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic clear,
  input  logic en,
  input  logic access,
  output logic pending_q,
  output logic irq_q
);
  logic pending_d, irq_d, reissue;

  assign reissue = access && pending_q && !clear;

  always_comb begin
    pending_d = pending_q;
    if (match)      pending_d = 1'b1;
    else if (clear) pending_d = 1'b0;
    irq_d = en && (match || reissue);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      pending_q <= pending_d;
      irq_q     <= irq_d;
    end
  end

  p_match_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> pending_q);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !match) |=> !pending_q);
  p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq_q);
  p_collide_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (match && clear) |=> pending_q);
endmodule

// File: rtl/wake_timer_top.sv
module wake_timer_top
  import wt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq_req
);
  logic             rst_meta_n, rst_sync_n;
  logic [CNT_W-1:0] period_q, count_q;
  logic             commit, en_q, clear, match, pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  wt_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .count    (count_q),
    .pending  (pending_q),
    .period_q (period_q),
    .commit   (commit),
    .en_q     (en_q),
    .clear    (clear),
    .rdata    (reg_rdata)
  );

  wt_count u_count (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (tick_32k),
    .commit   (commit),
    .period_q (period_q),
    .count_q  (count_q),
    .match    (match)
  );

  wt_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .match     (match),
    .clear     (clear),
    .en        (en_q),
    .access    (reg_wr || reg_rd),
    .pending_q (pending_q),
    .irq_q     (irq_req)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_sync_n |=> !irq_req);
endmodule

// File: tb/wake_timer_top_tb.sv
module wake_timer_top_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_32k, reg_wr, reg_rd;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq_req;

  int compared = 0;
  int mismatched = 0;

  logic [31:0] m_per, m_cnt, m_hold, m_stage;
  logic        m_en, m_pend;

  always #5 clk = ~clk;

  wake_timer_top u_dut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req)
  );

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    case (a)
      4'd0: return m_per[7:0];
      4'd1: return m_per[15:8];
      4'd2: return m_per[23:16];
      4'd3: return m_per[31:24];
      4'd4: return m_cnt[7:0];
      4'd5: return m_hold[15:8];
      4'd6: return m_hold[23:16];
      4'd7: return m_hold[31:24];
      4'd8: return {5'b0, m_pend, 1'b0, m_en};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic [3:0] a,
                      input logic [7:0] d, input logic t, input string tag);
    logic commit, match, clr, reissue, exp_irq;
    @(negedge clk);
    reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d; tick_32k = t;
    #1;
    if (r) check8({tag, " rdata"}, reg_rdata, exp_read(a));
    commit  = w && (a == 4'd0);
    match   = t && !commit && (m_per != 0) && (m_cnt + 1 == m_per);
    clr     = w && (a == 4'd8) && d[1];
    reissue = (w || r) && m_pend && !clr;
    exp_irq = m_en && (match || reissue);
    if (r && a == 4'd4) m_hold = m_cnt;
    if (commit) m_cnt = 0;
    else if (t && m_per != 0) m_cnt = match ? 0 : m_cnt + 1;
    if (match) m_pend = 1'b1;
    else if (clr) m_pend = 1'b0;
    if (w && a == 4'd8) m_en = d[0];
    if (commit) m_per = {m_stage[31:8], d};
    if (w && a == 4'd1) m_stage[15:8] = d;
    if (w && a == 4'd2) m_stage[23:16] = d;
    if (w && a == 4'd3) m_stage[31:24] = d;
    @(posedge clk);
    #1;
    check8({tag, " irq_req"}, {7'b0, irq_req}, {7'b0, exp_irq});
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 4'd0, 8'h00, 1'b1, tag);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got hung expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    m_per = 0; m_cnt = 0; m_hold = 0; m_stage = 0; m_en = 0; m_pend = 0;
    rst_n = 1'b0; tick_32k = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state on every address
    for (int a = 0; a < 10; a++) step(1'b0, 1'b1, 4'(a), 8'h00, 1'b0, "R1");

    // R2 staging, R3 commit, R5 counting
    step(1'b1, 1'b0, 4'd1, 8'h02, 1'b0, "R2");
    step(1'b0, 1'b1, 4'd1, 8'h00, 1'b0, "R2");
    step(1'b1, 1'b0, 4'd8, 8'h01, 1'b0, "R9");
    step(1'b1, 1'b0, 4'd0, 8'h00, 1'b1, "R3");
    step(1'b0, 1'b1, 4'd1, 8'h00, 1'b0, "R3");
    ticks(300, "R5");
    step(1'b0, 1'b0, 4'd0, 8'h00, 1'b0, "R5");
    // R6: coherent snapshot
    step(1'b0, 1'b1, 4'd4, 8'h00, 1'b0, "R6");
    ticks(5, "R6");
    step(1'b0, 1'b1, 4'd5, 8'h00, 1'b0, "R6");
    step(1'b0, 1'b1, 4'd6, 8'h00, 1'b0, "R6");
    step(1'b0, 1'b1, 4'd7, 8'h00, 1'b0, "R6");
    // R2: staged upper byte leaves running interval alone; R7 match
    step(1'b1, 1'b0, 4'd1, 8'h00, 1'b0, "R2");
    ticks(215, "R7");
    step(1'b0, 1'b1, 4'd8, 8'h00, 1'b0, "R7");
    // R9: clear, bit reads 0
    step(1'b1, 1'b0, 4'd8, 8'h03, 1'b0, "R9");
    step(1'b0, 1'b1, 4'd8, 8'h00, 1'b0, "R9");
    // R4: zero interval
    step(1'b1, 1'b0, 4'd0, 8'h00, 1'b0, "R4");
    ticks(20, "R4");
    step(1'b0, 1'b1, 4'd4, 8'h00, 1'b0, "R4");
    // R10: disabled interrupts, pending still sets
    step(1'b1, 1'b0, 4'd8, 8'h00, 1'b0, "R10");
    step(1'b1, 1'b0, 4'd0, 8'h03, 1'b0, "R10");
    ticks(6, "R10");
    step(1'b0, 1'b1, 4'd8, 8'h00, 1'b0, "R10");
    // R8: accesses re-issue while pending
    step(1'b1, 1'b0, 4'd8, 8'h01, 1'b0, "R8");
    step(1'b0, 1'b1, 4'd2, 8'h00, 1'b0, "R8");
    step(1'b1, 1'b0, 4'd3, 8'h00, 1'b0, "R8");
    step(1'b1, 1'b0, 4'd8, 8'h03, 1'b0, "R8");
    step(1'b0, 1'b1, 4'd0, 8'h00, 1'b0, "R8");
    // R11: match and clear together
    step(1'b1, 1'b0, 4'd0, 8'h02, 1'b0, "R11");
    step(1'b0, 1'b0, 4'd0, 8'h00, 1'b1, "R11");
    step(1'b1, 1'b0, 4'd8, 8'h03, 1'b1, "R11");
    step(1'b0, 1'b1, 4'd8, 8'h00, 1'b0, "R11");

    // random mix covering R5 R7 R8 R9 R11
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom % 10;
      logic t = 1'($urandom % 2);
      if (op < 1) begin
        int b = 1 + ($urandom % 3);
        step(1'b1, 1'b0, 4'(b), (($urandom % 8) == 0) ? 8'($urandom) : 8'h00, t, "R2 rand");
      end else if (op < 2)
        step(1'b1, 1'b0, 4'd0, 8'($urandom % 8), t, "R3 rand");
      else if (op < 3)
        step(1'b1, 1'b0, 4'd8, 8'($urandom % 4), t, "R9 rand");
      else if (op < 6)
        step(1'b0, 1'b1, 4'($urandom % 10), 8'h00, t, "R6 rand");
      else
        step(1'b0, 1'b0, 4'd0, 8'h00, t, "R5 rand");
    end
    step(1'b0, 1'b0, 4'd0, 8'h00, 1'b0, "R7 idle");

    summary();
    $finish;
  end
endmodule